// File: doc/BRIEF.md
# AC'97 Outgoing Link Frame Assembler

This block builds one outgoing serial link frame per sync period for an AC'97 controller and shifts it out on the serial data line, one bit per bit clock, starting with the MSB. Its inputs are a pending codec register command, the playback samples and two configuration bits. The command carries a read/write flag, a 9-bit driver offset, 16 bits of write data and a pending flag. The samples are left, right, an optional centre and a modem DAC sample, each with a valid flag. The configuration bits select 16- or 20-bit audio and enable six-channel mode.

The frame is 256 bits long: a 16-bit tag slot followed by twelve 20-bit slots. Every slot has its own zero-stuffing rule. The block converts the driver offset into a codec ID, which goes in the tag, and a 7-bit register address, which goes in slot 1. All inputs are captured together once per frame. A one-cycle strobe tells the host when the next frame's inputs may be presented.

Top module: `aclink_out_framer`

## Requirements
- R1: A frame is 256 bit times. Frame bit k (k=0 is the tag MSB) is on `sdata_out` during the (k+1)-th cycle after the loading edge. `sync_out` is high for exactly the 16 tag bit times and low for the other 240.
- R2: `frame_done` is high for exactly one cycle, the cycle that carries frame bit 0. All inputs are sampled at the single edge that ends the previous frame's last bit. Changes to the inputs at any other time have no effect on the frame.
- R3: The tag is laid out as follows. Bit 15 is set when any of slots 1–6 is valid. Bits 14..9 are the valid flags of slots 1..6, in that order. Slot 1 is valid when a command is pending. Slot 2 is valid for a pending write only. Slots 3, 4 and 5 are valid when the left, right and modem samples are valid. Slot 6 is valid when the centre sample is valid and six-channel mode is on. Bits 8..2 are zero.
- R4: Slot 1 bit 19 is 1 for a read and 0 for a write. Bits 18..12 hold the offset's low 7 bits with bit 0 forced to zero, since only even registers exist. Bits 11..0 are zero. The whole slot is zero when no command is pending.
- R5: Tag bits 1..0 hold the codec ID when a command is pending, and are zero otherwise. Offsets 000h–07Fh give ID 0. Offsets 080h–0FFh give ID 1. Offsets 100h–1FFh give ID 2.
- R6: Slot 2 carries the write data in bits 19..4 with bits 3..0 zero for a pending write. It is all zero for a read or when no command is pending.
- R7: Slots 3 and 4 carry the left and right samples, whose inputs are left-justified 20-bit words. In 20-bit mode the sample goes out unchanged. In 16-bit mode bits 3..0 are zeroed. A slot whose sample is not valid is all zero.
- R8: Slot 5 carries the 16-bit modem sample in bits 19..4 with bits 3..0 zero, or all zero when that sample is not valid.
- R9: Slot 6 carries the centre sample in the slot 3 format only when six-channel mode is on and the sample is valid. Otherwise it is all zero.
- R10: Slots 7 through 12 are always all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low reset |
| cmd_pending | input | 1 | A register command is to be sent |
| cmd_is_read | input | 1 | 1 = read command, 0 = write |
| cmd_offset | input | 9 | Driver register offset (codec range + register) |
| cmd_wdata | input | 16 | Register write data |
| pcm_left | input | 20 | Left playback sample, left-justified |
| pcm_left_vld | input | 1 | Left sample valid |
| pcm_right | input | 20 | Right playback sample, left-justified |
| pcm_right_vld | input | 1 | Right sample valid |
| pcm_center | input | 20 | Centre front sample, left-justified |
| pcm_center_vld | input | 1 | Centre sample valid |
| modem_dac | input | 16 | Modem DAC sample |
| modem_dac_vld | input | 1 | Modem sample valid |
| cfg_wide | input | 1 | 1 = 20-bit audio, 0 = 16-bit audio |
| cfg_six_ch | input | 1 | Six-channel mode enable |
| sdata_out | output | 1 | Serial frame data, MSB first |
| sync_out | output | 1 | Frame sync, high during the tag slot |
| frame_done | output | 1 | One-cycle strobe: next frame's inputs may be presented |

## Verification
Inputs are captured at the edge that ends bit 255 of the previous frame, and frame bit k then appears k+1 edges after that capture. `frame_done` therefore shows up in the same cycle as bit 0, and inputs presented then reach the wire 256 cycles later, in the next frame. The bench samples all outputs on falling edges. It starts collecting a frame at the falling edge where `frame_done` is seen and takes one bit per falling edge for 256 edges. Each collected frame is compared field by field against the expected item the driver queued when it presented those inputs. To show that mid-frame changes are ignored, the driver first holds garbage on the inputs for 50 cycles and only then presents the real values.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int TAG_W    = 16;
  localparam int SLOT_W   = 20;
  localparam int NSLOT    = 12;
  localparam int NDSLOT   = 6;
  localparam int SHORT_W  = 16;
  localparam int PAD_W    = SLOT_W - SHORT_W;
  localparam int OFF_W    = 9;
  localparam int ADDR_W   = 7;
  localparam int CID_W    = 2;
  localparam int BODY_W   = NSLOT * SLOT_W;
  localparam int FRAME_W  = TAG_W + BODY_W;
  localparam int CNT_W    = $clog2(FRAME_W);
  localparam int S1_PAD_W = SLOT_W - 1 - ADDR_W;

  // Offset range -> codec ID on the link.
  function automatic logic [CID_W-1:0] codec_of(input logic [OFF_W-1:0] off);
    return off[OFF_W-1] ? CID_W'(2) : {1'b0, off[ADDR_W]};
  endfunction

  // Register address sent in slot 1: even addresses only.
  function automatic logic [ADDR_W-1:0] reg_of(input logic [OFF_W-1:0] off);
    return off[ADDR_W-1:0] & ~ADDR_W'(1);
  endfunction

  // Narrow or full-width left-justified sample.
  function automatic logic [SLOT_W-1:0] justify(input logic [SLOT_W-1:0] s,
                                                input logic wide);
    return wide ? s : {s[SLOT_W-1:PAD_W], {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/aclink_tag_gen.sv
module aclink_tag_gen
  import aclink_pkg::*;
(
  input  logic               cmd_pending,
  input  logic               cmd_is_read,
  input  logic [OFF_W-1:0]   cmd_offset,
  input  logic               left_vld,
  input  logic               right_vld,
  input  logic               center_vld,
  input  logic               modem_vld,
  input  logic               six_ch,
  output logic [NDSLOT:1]    slot_vld,
  output logic [TAG_W-1:0]   tag
);
  always_comb begin
    slot_vld[1] = cmd_pending;
    slot_vld[2] = cmd_pending & ~cmd_is_read;
    slot_vld[3] = left_vld;
    slot_vld[4] = right_vld;
    slot_vld[5] = modem_vld;
    slot_vld[6] = center_vld & six_ch;
  end

  always_comb begin
    tag = '0;
    tag[TAG_W-1] = |slot_vld;
    for (int s = 1; s <= NDSLOT; s++) tag[TAG_W-1-s] = slot_vld[s];
    tag[CID_W-1:0] = cmd_pending ? codec_of(cmd_offset) : '0;
  end

  always_comb begin
    assert_slot2_needs_slot1_R3: assert (!slot_vld[2] || slot_vld[1]);
  end
endmodule

// File: rtl/aclink_slot_pack.sv
module aclink_slot_pack
  import aclink_pkg::*;
(
  input  logic [NDSLOT:1]     slot_vld,
  input  logic                cmd_is_read,
  input  logic [OFF_W-1:0]    cmd_offset,
  input  logic [SHORT_W-1:0]  cmd_wdata,
  input  logic [SLOT_W-1:0]   pcm_left,
  input  logic [SLOT_W-1:0]   pcm_right,
  input  logic [SLOT_W-1:0]   pcm_center,
  input  logic [SHORT_W-1:0]  modem_dac,
  input  logic                wide,
  output logic [BODY_W-1:0]   body,
  output logic [SLOT_W-1:0]   slot2_word,
  output logic [SLOT_W-1:0]   slot6_word
);
  logic [SLOT_W-1:0] words [NSLOT];

  for (genvar s = 1; s <= NSLOT; s++) begin : g_slot
    if (s == 1) begin : g_cmd
      assign words[s-1] = slot_vld[1]
        ? {cmd_is_read, reg_of(cmd_offset), {S1_PAD_W{1'b0}}} : '0;
    end else if (s == 2) begin : g_wdat
      assign words[s-1] = slot_vld[2] ? {cmd_wdata, {PAD_W{1'b0}}} : '0;
    end else if (s == 3) begin : g_left
      assign words[s-1] = slot_vld[3] ? justify(pcm_left, wide) : '0;
    end else if (s == 4) begin : g_right
      assign words[s-1] = slot_vld[4] ? justify(pcm_right, wide) : '0;
    end else if (s == 5) begin : g_modem
      assign words[s-1] = slot_vld[5] ? {modem_dac, {PAD_W{1'b0}}} : '0;
    end else if (s == 6) begin : g_center
      assign words[s-1] = slot_vld[6] ? justify(pcm_center, wide) : '0;
    end else begin : g_idle
      assign words[s-1] = '0;
    end
    assign body[BODY_W-1-(s-1)*SLOT_W -: SLOT_W] = words[s-1];
  end

  assign slot2_word = words[1];
  assign slot6_word = words[5];
endmodule

// File: rtl/aclink_serializer.sv
module aclink_serializer
  import aclink_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               sdo,
  output logic               sync,
  output logic               frame_done,
  output logic               load_evt
);
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shreg;

  assign load_evt = (bit_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else begin
      bit_cnt <= bit_cnt + CNT_W'(1);
      if (load_evt) shreg <= frame_in;
      else          shreg <= {shreg[FRAME_W-2:0], 1'b0};
    end
  end

  assign sdo        = shreg[FRAME_W-1];
  assign sync       = (bit_cnt >= CNT_W'(1)) && (bit_cnt <= CNT_W'(TAG_W));
  assign frame_done = (bit_cnt == CNT_W'(1));

  assert_sync_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync) |-> bit_cnt == CNT_W'(TAG_W + 1));
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  assert_done_at_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> frame_done);
endmodule

// File: rtl/aclink_out_framer.sv
module aclink_out_framer
  import aclink_pkg::*;
(
  input  logic         bit_clk,
  input  logic         rst_n,
  input  logic         cmd_pending,
  input  logic         cmd_is_read,
  input  logic [8:0]   cmd_offset,
  input  logic [15:0]  cmd_wdata,
  input  logic [19:0]  pcm_left,
  input  logic         pcm_left_vld,
  input  logic [19:0]  pcm_right,
  input  logic         pcm_right_vld,
  input  logic [19:0]  pcm_center,
  input  logic         pcm_center_vld,
  input  logic [15:0]  modem_dac,
  input  logic         modem_dac_vld,
  input  logic         cfg_wide,
  input  logic         cfg_six_ch,
  output logic         sdata_out,
  output logic         sync_out,
  output logic         frame_done
);
  logic [NDSLOT:1]    slot_vld;
  logic [TAG_W-1:0]   tag;
  logic [BODY_W-1:0]  body;
  logic [SLOT_W-1:0]  slot2_word;
  logic [SLOT_W-1:0]  slot6_word;
  logic               load_evt;

  aclink_tag_gen u_tag (
    .cmd_pending (cmd_pending),
    .cmd_is_read (cmd_is_read),
    .cmd_offset  (cmd_offset),
    .left_vld    (pcm_left_vld),
    .right_vld   (pcm_right_vld),
    .center_vld  (pcm_center_vld),
    .modem_vld   (modem_dac_vld),
    .six_ch      (cfg_six_ch),
    .slot_vld    (slot_vld),
    .tag         (tag)
  );

  aclink_slot_pack u_pack (
    .slot_vld    (slot_vld),
    .cmd_is_read (cmd_is_read),
    .cmd_offset  (cmd_offset),
    .cmd_wdata   (cmd_wdata),
    .pcm_left    (pcm_left),
    .pcm_right   (pcm_right),
    .pcm_center  (pcm_center),
    .modem_dac   (modem_dac),
    .wide        (cfg_wide),
    .body        (body),
    .slot2_word  (slot2_word),
    .slot6_word  (slot6_word)
  );

  aclink_serializer u_ser (
    .clk        (bit_clk),
    .rst_n      (rst_n),
    .frame_in   ({tag, body}),
    .sdo        (sdata_out),
    .sync       (sync_out),
    .frame_done (frame_done),
    .load_evt   (load_evt)
  );

  assert_read_no_data_R6: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (load_evt && (cmd_is_read || !cmd_pending)) |-> slot2_word == '0);
  assert_center_gated_R9: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (load_evt && !cfg_six_ch) |-> slot6_word == '0);
endmodule

// File: tb/aclink_out_framer_tb.sv
module aclink_out_framer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  typedef struct packed {
    logic        pend, rd;
    logic [8:0]  off;
    logic [15:0] wdata;
    logic [19:0] l;  logic lv;
    logic [19:0] r;  logic rv;
    logic [19:0] c;  logic cv;
    logic [15:0] m;  logic mv;
    logic        w20, six;
  } vec_t;

  logic bit_clk = 0, rst_n = 0;
  logic cmd_pending, cmd_is_read, pcm_left_vld, pcm_right_vld, pcm_center_vld;
  logic modem_dac_vld, cfg_wide, cfg_six_ch;
  logic [8:0] cmd_offset; logic [15:0] cmd_wdata, modem_dac;
  logic [19:0] pcm_left, pcm_right, pcm_center;
  logic sdata_out, sync_out, frame_done;

  int checks = 0, failures = 0;
  vec_t expq[$];
  vec_t vecs [NVEC];

  always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

  aclink_out_framer u_dut (.*);

  task automatic apply(input vec_t v);
    cmd_pending = v.pend; cmd_is_read = v.rd; cmd_offset = v.off; cmd_wdata = v.wdata;
    pcm_left = v.l; pcm_left_vld = v.lv; pcm_right = v.r; pcm_right_vld = v.rv;
    pcm_center = v.c; pcm_center_vld = v.cv; modem_dac = v.m; modem_dac_vld = v.mv;
    cfg_wide = v.w20; cfg_six_ch = v.six;
  endtask

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] trim(input logic [19:0] x, input logic w20);
    return w20 ? x : (x >> 4) << 4;
  endfunction

  function automatic logic [19:0] exp_slot(input vec_t v, input int s);
    logic [19:0] addr;
    addr = 20'((v.off % 128) / 2 * 2);
    case (s)
      1: return v.pend ? ({19'b0, v.rd} << 19) | (addr << 12) : 20'h0;
      2: return (v.pend && !v.rd) ? {v.wdata, 4'h0} : 20'h0;
      3: return v.lv ? trim(v.l, v.w20) : 20'h0;
      4: return v.rv ? trim(v.r, v.w20) : 20'h0;
      5: return v.mv ? 20'(v.m) * 16 : 20'h0;
      6: return (v.cv && v.six) ? trim(v.c, v.w20) : 20'h0;
      default: return 20'h0;
    endcase
  endfunction

  function automatic logic [15:0] exp_tag(input vec_t v);
    logic [5:0] vb; int id;
    vb = {exp_slot(v,1) != 0 || v.pend, v.pend && !v.rd, v.lv, v.rv, v.mv, v.cv && v.six};
    id = v.pend ? ((v.off / 128) > 2 ? 2 : v.off / 128) : 0;
    return {(vb != 0), vb, 7'b0, 2'(id)};
  endfunction

  // Driver: garbage mid-frame, then real inputs for the next frame.
  initial begin
    vecs[0] = '{pend:1, rd:0, off:9'h002, wdata:16'hA5C3, l:20'h12345, lv:1,
                r:20'hFEDCB, rv:1, c:20'h55555, cv:1, m:16'hBEEF, mv:1, w20:0, six:0};
    vecs[1] = '{pend:1, rd:1, off:9'h08C, wdata:16'h1234, l:20'hABCDE, lv:1,
                r:20'h0000F, rv:0, c:20'h9876F, cv:1, m:16'h0001, mv:0, w20:1, six:1};
    vecs[2] = '{pend:0, rd:0, off:9'h1FF, wdata:16'hFFFF, l:20'hFFFFF, lv:0,
                r:20'hFFFFF, rv:0, c:20'hFFFFF, cv:1, m:16'hFFFF, mv:0, w20:1, six:0};
    vecs[3] = '{pend:1, rd:0, off:9'h11F, wdata:16'hFFFF, l:20'h8000F, lv:1,
                r:20'h7FFF1, rv:1, c:20'h13579, cv:0, m:16'h8001, mv:1, w20:1, six:1};
    vecs[4] = '{pend:1, rd:1, off:9'h07F, wdata:16'hDEAD, l:20'hFFFFF, lv:0,
                r:20'h3C3C3, rv:1, c:20'hFFFFF, cv:1, m:16'h7777, mv:1, w20:0, six:1};
    vecs[5] = '{pend:1, rd:0, off:9'h1FE, wdata:16'h0F0F, l:20'h00010, lv:1,
                r:20'h00000, rv:1, c:20'hC0FFE, cv:1, m:16'h0000, mv:1, w20:1, six:1};
    apply(vecs[0]);
    expq.push_back(vecs[0]);
    repeat (3) @(negedge bit_clk);
    // reset state
    check(sdata_out == 0 && sync_out == 0 && frame_done == 0, "R1 reset outputs",
          256'({sdata_out, sync_out, frame_done}), 256'(0));
    rst_n = 1;
    for (int i = 1; i < NVEC; i++) begin
      do @(negedge bit_clk); while (!frame_done);
      apply('1);
      repeat (50) @(negedge bit_clk);
      apply(vecs[i]);
      expq.push_back(vecs[i]);
    end
  end

  // Monitor / scoreboard.
  initial begin
    int nfr = 0;
    logic [255:0] cap, expf;
    bit sync_ok, done_ok;
    vec_t v;
    while (nfr < NVEC) begin
      @(negedge bit_clk);
      if (rst_n && frame_done) begin
        sync_ok = 1; done_ok = 1;
        for (int k = 0; k < 256; k++) begin
          if (k > 0) @(negedge bit_clk);
          cap[255-k] = sdata_out;
          if (sync_out != (k < 16)) sync_ok = 0;
          if (k > 0 && frame_done) done_ok = 0;
        end
        v = expq.pop_front();
        expf = {exp_tag(v), 240'b0};
        for (int s = 1; s <= 12; s++) expf[239-(s-1)*20 -: 20] = exp_slot(v, s);
        check(sync_ok, "R1 sync high 16 of 256", 256'(sync_ok), 256'(1));
        check(done_ok, "R2 frame_done one cycle", 256'(done_ok), 256'(1));
        check(cap == expf, "R2 whole frame, mid-frame input changes ignored", cap, expf);
        check(cap[255:242] == expf[255:242], "R3 tag valid bits", 256'(cap[255:242]), 256'(expf[255:242]));
        check(cap[241:240] == expf[241:240], "R5 codec id", 256'(cap[241:240]), 256'(expf[241:240]));
        check(cap[239:220] == expf[239:220], "R4 slot1", 256'(cap[239:220]), 256'(expf[239:220]));
        check(cap[219:200] == expf[219:200], "R6 slot2", 256'(cap[219:200]), 256'(expf[219:200]));
        check(cap[199:160] == expf[199:160], "R7 slots 3/4", 256'(cap[199:160]), 256'(expf[199:160]));
        check(cap[159:140] == expf[159:140], "R8 slot5", 256'(cap[159:140]), 256'(expf[159:140]));
        check(cap[139:120] == expf[139:120], "R9 slot6", 256'(cap[139:120]), 256'(expf[139:120]));
        check(cap[119:0] == 120'b0, "R10 slots 7-12 zero", 256'(cap[119:0]), 256'(0));
        nfr++;
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge bit_clk);
    checks++; failures++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule